// File: doc/BRIEF.md
# Framed Serial ADC Lane Receiver

This block turns the serial output of a four-channel converter back into parallel samples. The capture logic ahead of it delivers two bits per lane on every bit-clock cycle. One is the bit taken on the rising edge and the other is the bit taken on the falling edge. The same pair arrives for a fifth lane that carries a frame marker. Six bit-clock cycles therefore carry one 12-bit sample per data lane.

The word boundary is not known in advance. The receiver keeps a short bit history of the frame lane and hunts for the marker's rising edge at every one of the twelve possible bit offsets. It then confirms that offset over several words before it declares alignment. The same offset cuts all four data lanes. The four samples are presented together with a one-cycle valid strobe. They are given either as received (offset binary) or with the top bit inverted (two's complement).

Top module: `srx_quad_rx`

## Requirements
- R1: While reset is applied, and after it is applied, `align_locked`, `sample_valid` and every bit of `sample_word` read 0. Alignment hunting restarts from scratch.
- R2: On each lane the rise-edge bit is older than the fall-edge bit of the same cycle. The earliest bit of a word is its MSB. A word appears on `sample_word` at the clock edge after the cycle that delivered its last bit.
- R3: The bit that directly follows a 0-to-1 change on the frame lane is taken as the MSB. The frame pattern is six ones then six zeros. It is found whichever of the 12 bit offsets it sits at, including offsets that start on a fall-edge bit.
- R4: `align_locked` rises after 4 consecutive words show the frame pattern at one offset. It rises on the same edge that first raises `sample_valid`.
- R5: While locked, one word without the frame pattern keeps the lock, and that word is still delivered. A second consecutive miss drops the lock with no strobe, and a fresh hunt begins.
- R6: Before lock is declared, a single word without the frame pattern discards the candidate offset. The hunt starts again.
- R7: `sample_valid` is high for exactly one bit-clock cycle per word, and only while `align_locked` is high.
- R8: All four lanes use the same bit offset. Their words on `sample_word` change on the same edge. Lane n occupies bits [12n+11:12n].
- R9: When `twos_comp` is high at the cycle a word is taken, bit 11 of each lane word is inverted. When it is low, the word is passed unchanged as offset binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one rise/fall bit pair per lane per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_rise | input | 1 | Frame-lane bit captured on the rising edge |
| frame_fall | input | 1 | Frame-lane bit captured on the falling edge |
| lane_rise | input | 4 | Data-lane bits captured on the rising edge, one per lane |
| lane_fall | input | 4 | Data-lane bits captured on the falling edge, one per lane |
| twos_comp | input | 1 | 1 = invert MSB of each word (two's complement output) |
| sample_word | output | 48 | Four 12-bit words, lane n in bits [12n+11:12n] |
| sample_valid | output | 1 | One-cycle strobe for a new set of four words |
| align_locked | output | 1 | Word alignment established |

## Verification
The word boundary check and the strobe both fall on the sixth cycle of a word, so several aligner events share that cycle with delivery. The fourth confirming word raises the lock on the same edge as the first strobe. A first miss while locked must still strobe the word, and the second miss must drop the lock with no strobe. The bench provokes these by corrupting one or two whole frame words and by shifting the frame offset mid-stream. It toggles `twos_comp` between words. A behavioural model holds the bit stream in a queue and predicts the lock and strobe on every clock. The bench compares all four words against that prediction.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Alignment sequencer states
  typedef enum logic [1:0] {
    ALN_HUNT    = 2'd0,
    ALN_CONFIRM = 2'd1,
    ALN_LOCKED  = 2'd2
  } aln_state_e;

endpackage

// File: rtl/srx_lane_hist.sv
// Per-lane bit history: two bits enter per cycle, rise bit older than fall bit.
module srx_lane_hist #(
  parameter int WORD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            early_bit,
  input  logic            late_bit,
  output logic [WORD_W:0] hist
);

  logic [WORD_W:0] hist_q;
  logic [WORD_W:0] hist_d;

  always_comb begin
    hist_d = {hist_q[WORD_W-2:0], early_bit, late_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

  // R2: rise bit lands above fall bit, older bits move up by two
  a_r2_bit_order: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (hist_q[1] == $past(early_bit)) && (hist_q[0] == $past(late_bit)));

  a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> hist_q[WORD_W:2] == $past(hist_q[WORD_W-2:0]));

endmodule

// File: rtl/srx_frame_align.sv
// Hunts for the frame marker at any bit offset, confirms it, tracks lock.
module srx_frame_align
  import srx_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int LOCK_WORDS  = 4,
  parameter int DROP_MISSES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WORD_W:0] frame_hist,
  output logic            odd_par,
  output logic            take,
  output logic            locked
);

  localparam int CYC    = WORD_W / 2;
  localparam int HALF   = WORD_W / 2;
  localparam int PH_W   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int GOOD_W = $clog2(LOCK_WORDS + 1);
  localparam int MISS_W = $clog2(DROP_MISSES + 1);
  localparam logic [WORD_W-1:0] FRAME_REF = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(CYC - 1);

  aln_state_e        state_q, state_d;
  logic              par_q, par_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [MISS_W-1:0] miss_q, miss_d;

  logic hit_even, hit_odd, cur_hit, boundary;

  // Window ending on the newest bit (even) or one bit earlier (odd)
  assign hit_even = (frame_hist[WORD_W-1:0] == FRAME_REF);
  assign hit_odd  = (frame_hist[WORD_W:1]   == FRAME_REF);
  assign cur_hit  = par_q ? hit_odd : hit_even;
  assign boundary = (state_q != ALN_HUNT) && (phase_q == PH_LAST);

  always_comb begin
    state_d = state_q;
    par_d   = par_q;
    phase_d = phase_q;
    good_d  = good_q;
    miss_d  = miss_q;
    if (state_q != ALN_HUNT) begin
      phase_d = boundary ? '0 : phase_q + PH_W'(1);
    end
    case (state_q)
      ALN_HUNT: begin
        if (hit_even || hit_odd) begin
          state_d = ALN_CONFIRM;
          par_d   = !hit_even;
          phase_d = '0;
          good_d  = GOOD_W'(1);
        end
      end
      ALN_CONFIRM: begin
        if (boundary) begin
          if (cur_hit) begin
            if (good_q == GOOD_W'(LOCK_WORDS - 1)) begin
              state_d = ALN_LOCKED;
              miss_d  = '0;
            end else begin
              good_d = good_q + GOOD_W'(1);
            end
          end else begin
            state_d = ALN_HUNT;
            good_d  = '0;
          end
        end
      end
      ALN_LOCKED: begin
        if (boundary) begin
          if (cur_hit) begin
            miss_d = '0;
          end else if (miss_q == MISS_W'(DROP_MISSES - 1)) begin
            state_d = ALN_HUNT;
            miss_d  = '0;
            good_d  = '0;
          end else begin
            miss_d = miss_q + MISS_W'(1);
          end
        end
      end
      default: state_d = ALN_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ALN_HUNT;
      par_q   <= 1'b0;
      phase_q <= '0;
      good_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      par_q   <= par_d;
      phase_q <= phase_d;
      good_q  <= good_d;
      miss_q  <= miss_d;
    end
  end

  assign odd_par = par_q;
  assign take    = boundary && (state_d == ALN_LOCKED);
  assign locked  = (state_q == ALN_LOCKED);

  // R3: a pattern seen while hunting starts a word count at phase zero
  a_r3_hunt_to_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ALN_HUNT && (hit_even || hit_odd)) |=> (state_q == ALN_CONFIRM && phase_q == '0));

  // R5: the lock only falls on a word boundary
  a_r5_drop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(phase_q) == PH_LAST);

  // R6: hunting always begins with cleared counters
  a_r6_hunt_counts_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ALN_HUNT) |-> (good_q == '0 && miss_q == '0));

endmodule

// File: rtl/srx_word_out.sv
// Selects the aligned window on each lane and registers all lanes together.
module srx_word_out #(
  parameter int LANES  = 4,
  parameter int WORD_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LANES*(WORD_W+1)-1:0]     lane_hist,
  input  logic                            odd_par,
  input  logic                            take,
  input  logic                            tc_en,
  output logic [LANES*WORD_W-1:0]         words,
  output logic                            vld
);

  localparam int HW = WORD_W + 1;

  logic [LANES*WORD_W-1:0] words_q, words_d;
  logic                    vld_q, vld_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HW-1:0]     h;
    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] conv;
    assign h    = lane_hist[g*HW +: HW];
    assign sel  = odd_par ? h[WORD_W:1] : h[WORD_W-1:0];
    assign conv = tc_en ? {~sel[WORD_W-1], sel[WORD_W-2:0]} : sel;
    always_comb begin
      words_d[g*WORD_W +: WORD_W] = take ? conv : words_q[g*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    vld_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      words_q <= words_d;
      vld_q   <= vld_d;
    end
  end

  assign words = words_q;
  assign vld   = vld_q;

  // R8: no lane word changes except on a delivery edge
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(words_q));

endmodule

// File: rtl/srx_quad_rx.sv
module srx_quad_rx #(
  parameter int LANES       = 4,
  parameter int WORD_W      = 12,
  parameter int LOCK_WORDS  = 4,
  parameter int DROP_MISSES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_rise,
  input  logic                    frame_fall,
  input  logic [LANES-1:0]        lane_rise,
  input  logic [LANES-1:0]        lane_fall,
  input  logic                    twos_comp,
  output logic [LANES*WORD_W-1:0] sample_word,
  output logic                    sample_valid,
  output logic                    align_locked
);

  localparam int HW = WORD_W + 1;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_s1_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  logic [HW-1:0]          frame_hist;
  logic [LANES*HW-1:0]    lane_hist;
  logic                   odd_par, take;

  srx_lane_hist #(.WORD_W(WORD_W)) u_frame_hist (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .early_bit (frame_rise),
    .late_bit  (frame_fall),
    .hist      (frame_hist)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_data
    srx_lane_hist #(.WORD_W(WORD_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .early_bit (lane_rise[g]),
      .late_bit  (lane_fall[g]),
      .hist      (lane_hist[g*HW +: HW])
    );
  end

  srx_frame_align #(
    .WORD_W      (WORD_W),
    .LOCK_WORDS  (LOCK_WORDS),
    .DROP_MISSES (DROP_MISSES)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_hist (frame_hist),
    .odd_par    (odd_par),
    .take       (take),
    .locked     (align_locked)
  );

  srx_word_out #(.LANES(LANES), .WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .lane_hist (lane_hist),
    .odd_par   (odd_par),
    .take      (take),
    .tc_en     (twos_comp),
    .words     (sample_word),
    .vld       (sample_valid)
  );

  // R7: strobe only while locked, and never two cycles running
  a_r7_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_core_n)
    sample_valid |-> align_locked);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_core_n)
    sample_valid |=> !sample_valid);

  // R4: lock is declared together with the first delivered word
  a_r4_lock_with_first_word: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(align_locked) |-> sample_valid);

  // R5: the edge that drops lock carries no word
  a_r5_drop_no_valid: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(align_locked) |-> !sample_valid);

endmodule

// File: tb/srx_quad_rx_tb.sv
module srx_quad_rx_tb;

  localparam int LANES = 4;
  localparam int WW    = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             frame_rise = 1'b0, frame_fall = 1'b0;
  logic [LANES-1:0] lane_rise = '0, lane_fall = '0;
  logic             twos_comp = 1'b0;
  logic [LANES*WW-1:0] sample_word;
  logic             sample_valid, align_locked;

  srx_quad_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_rise   (frame_rise),
    .frame_fall   (frame_fall),
    .lane_rise    (lane_rise),
    .lane_fall    (lane_fall),
    .twos_comp    (twos_comp),
    .sample_word  (sample_word),
    .sample_valid (sample_valid),
    .align_locked (align_locked)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // ---------------- stimulus generator ----------------
  int gb = 0, off = 0;
  bit stream_on = 0;
  int glitch_lo = -1, glitch_hi = -2;

  function automatic logic [11:0] sample_of(int lane, int w);
    int k;
    k = w % 9;
    if (k == 0) return 12'h800;
    if (k == 4) return 12'hFFF;
    if (k == 7) return 12'h000;
    return 12'(w * 397 + lane * 1111 + 77);
  endfunction

  function automatic logic [4:0] gen_bit(int b);
    logic [4:0]  r;
    logic [11:0] s;
    int t, pos, w;
    r = '0;
    if (stream_on) begin
      t = b + off; pos = t % 12; w = t / 12;
      r[0] = (pos < 6) || (w >= glitch_lo && w <= glitch_hi);
      for (int l = 0; l < LANES; l++) begin
        s = sample_of(l, w);
        r[l+1] = s[11-pos];
      end
    end
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [4:0]  mq[$];          // bit-time history, [0]=frame, [1+l]=lane l
  int          m_rs1, m_rs2, mst, mpar, mph, mgood, mmiss;
  bit          e_vld, e_lock;
  logic [11:0] e_word [LANES];

  function automatic void model_clear();
    mq.delete();
    for (int i = 0; i < 13; i++) mq.push_back(5'b0);
    mst = 0; mpar = 0; mph = 0; mgood = 0; mmiss = 0;
    e_vld = 0; e_lock = 0;
    for (int l = 0; l < LANES; l++) e_word[l] = '0;
  endfunction

  function automatic int win(int l, int p);
    int v;
    v = 0;
    for (int i = 0; i < 12; i++) v = (v << 1) | int'(mq[1 - p + i][l]);
    return v;
  endfunction

  function automatic void model_edge(logic [4:0] a, logic [4:0] b);
    bit h0, h1, hit, bnd, tk;
    int w;
    if (!rst_n) begin
      model_clear(); m_rs1 = 0; m_rs2 = 0; return;
    end
    if (m_rs2 == 0) begin
      m_rs2 = m_rs1; m_rs1 = 1; model_clear(); return;
    end
    m_rs2 = m_rs1; m_rs1 = 1;
    h0  = (win(0, 0) == 12'hFC0);
    h1  = (win(0, 1) == 12'hFC0);
    bnd = (mst != 0) && (mph == 5);
    if (mst == 0) begin
      if (h0 || h1) begin mpar = h0 ? 0 : 1; mph = 0; mgood = 1; mst = 1; end
    end else begin
      hit = (win(0, mpar) == 12'hFC0);
      if (bnd) begin
        if (mst == 1) begin
          if (hit) begin
            if (mgood == 3) begin mst = 2; mmiss = 0; end
            else mgood++;
          end else begin mst = 0; mgood = 0; end
        end else begin
          if (hit) mmiss = 0;
          else if (mmiss == 1) begin mst = 0; mmiss = 0; mgood = 0; end
          else mmiss++;
        end
      end
      mph = (mph == 5) ? 0 : mph + 1;
    end
    tk = bnd && (mst == 2);
    e_vld = tk;
    if (tk) begin
      for (int l = 0; l < LANES; l++) begin
        w = win(l + 1, mpar);
        if (twos_comp) w = w ^ 12'h800;
        e_word[l] = 12'(w);
      end
    end
    e_lock = (mst == 2);
    mq.push_back(a); mq.push_back(b);
    void'(mq.pop_front()); void'(mq.pop_front());
  endfunction

  // ---------------- checking ----------------
  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  int falls = 0, rises = 0, vld_seen = 0;
  bit prev_lock = 0;

  task automatic tick();
    logic [4:0] a, b;
    @(negedge clk);
    check(align_locked === e_lock, "R4 R5 R6 lock", int'(align_locked), int'(e_lock));
    check(sample_valid === e_vld, "R7 valid", int'(sample_valid), int'(e_vld));
    for (int l = 0; l < LANES; l++)
      check(sample_word[l*WW +: WW] === e_word[l], "R2 R3 R8 R9 word",
            int'(sample_word[l*WW +: WW]), int'(e_word[l]));
    if (prev_lock && !align_locked) falls++;
    if (!prev_lock && align_locked) rises++;
    if (sample_valid) vld_seen++;
    prev_lock = align_locked;
    a = gen_bit(gb);
    b = gen_bit(gb + 1);
    if (stream_on) gb += 2;
    frame_rise = a[0]; frame_fall = b[0];
    lane_rise  = a[4:1]; lane_fall = b[4:1];
    model_edge(a, b);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear(); m_rs1 = 0; m_rs2 = 0;
    stream_on = 0; gb = 0;
    #1;
    // R1: outputs clear as soon as reset is applied
    check(align_locked === 1'b0 && sample_valid === 1'b0 && sample_word === '0,
          "R1 reset outputs", int'(sample_word[11:0]), 0);
    run(3);
    rst_n = 1'b1;
    run(3);
  endtask

  function automatic int cur_word();
    return (gb + off) / 12;
  endfunction

  int t_plain, t_glitch;

  task automatic ticks_to_lock(output int t);
    t = 0;
    while (!align_locked && t < 200) begin tick(); t++; end
  endtask

  initial begin
    model_clear(); m_rs1 = 0; m_rs2 = 0;
    run(4);
    check(align_locked === 1'b0 && sample_valid === 1'b0, "R1 held in reset",
          int'(align_locked), 0);
    rst_n = 1'b1;
    run(4);

    // R2 R3 R4: aligned stream at offset 0
    off = 0; gb = 0; stream_on = 1;
    run(80);
    check(align_locked === 1'b1, "R4 locked at offset 0", int'(align_locked), 1);
    check(vld_seen > 0, "R7 words delivered", vld_seen, 1);

    // R5: one corrupted frame word while locked keeps lock
    falls = 0;
    glitch_lo = cur_word() + 2; glitch_hi = glitch_lo;
    run(48);
    check(falls == 0, "R5 single miss keeps lock", falls, 0);

    // R5: two consecutive corrupted words drop lock, then relock
    falls = 0; rises = 0;
    glitch_lo = cur_word() + 2; glitch_hi = glitch_lo + 1;
    run(90);
    check(falls == 1, "R5 double miss drops lock", falls, 1);
    check(rises == 1 && align_locked === 1'b1, "R5 relock after drop", rises, 1);

    // R9: two's complement output, toggled between words
    twos_comp = 1'b1;
    run(40);
    run(3);
    twos_comp = 1'b0;
    run(20);

    // R3: offset moves mid-stream to an odd bit position
    falls = 0;
    off = 7;
    run(100);
    check(falls == 1 && align_locked === 1'b1, "R3 relock at odd offset", falls, 1);

    // R6: compare lock time with and without a pre-lock miss
    do_reset();
    glitch_lo = -1; glitch_hi = -2;
    off = 11; gb = 0; stream_on = 1;
    ticks_to_lock(t_plain);
    run(30);
    do_reset();
    off = 11; gb = 0; stream_on = 1;
    glitch_lo = 2; glitch_hi = 2;
    ticks_to_lock(t_glitch);
    check(t_glitch > t_plain, "R6 pre-lock miss restarts hunt", t_glitch, t_plain + 1);
    run(30);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule